// File: doc/BRIEF.md
# DMA Handshake Peripheral Strobe Sequencer

This block sits beside a DMA controller that moves data between a byte-wide peripheral and system memory. When the controller acknowledges a transfer on either of its two active-low acknowledge lines, the sequencer drives the peripheral's active-low read or write strobe. It also controls a gate that lets the controller's upper and lower data strobes reach the system bus.

The transfer direction sets how the gate behaves. When data flows from the peripheral to memory, the sequencer holds the controller's data strobes off the bus until a fixed peripheral access time has been counted. When data flows from memory to the peripheral, the gate opens at once, so the strobes pass straight through. In that direction the peripheral write strobe is raised, which latches the data, as soon as the controller is seen to release its strobes.

After every transfer, the sequencer runs a recovery interval once the acknowledge is released. During that interval a ready flag is low and no new peripheral access may begin. All handshake inputs are synchronized inside the block before use.

Top module: `dma_strobe_seq`

## Requirements
- R1: A transfer starts when ack0_n, ack1_n or both are low. With two synchronizer flops, the first strobe change appears 3 rising clock edges after the acknowledge input falls. Both lines low together give one transfer only.
- R2: With dir_to_per = 0 (peripheral to memory), per_rd_n goes low at the start. ds_gate stays 0 for ACCESS_CYC cycles and then becomes 1. While ds_gate is 1, bus_uds_n and bus_lds_n follow uds_n and lds_n.
- R3: In a read transfer, per_rd_n returns high 3 edges after the acknowledge lines are both released.
- R4: With dir_to_per = 1 (memory to peripheral), per_wr_n goes low and ds_gate becomes 1 at the start. From then on, the bus strobes follow the controller strobes with no clock delay.
- R5: In a write transfer, per_wr_n returns high 3 edges after the controller's strobes have been seen low and then both released high.
- R6: In both directions, ready goes low 3 edges after the acknowledge release and stays low for exactly RECOV_CYC cycles.
- R7: No strobe goes low while ready is low. An acknowledge that is held low during recovery starts its transfer one cycle after ready returns high.
- R8: dir_to_per is sampled when the transfer starts. A change of dir_to_per later in the transfer has no effect on which strobe is driven.
- R9: While rst_n is low, and at once when it falls, per_rd_n = 1, per_wr_n = 1, ds_gate = 0, both bus strobes are high and ready = 1.
- R10: per_rd_n and per_wr_n are never low together. During recovery both are high and ds_gate is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (40 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack0_n | input | 1 | DMA acknowledge, channel 0, active low |
| ack1_n | input | 1 | DMA acknowledge, channel 1, active low |
| dir_to_per | input | 1 | 1: memory to peripheral, 0: peripheral to memory |
| uds_n | input | 1 | Controller upper data strobe, active low |
| lds_n | input | 1 | Controller lower data strobe, active low |
| per_rd_n | output | 1 | Peripheral read strobe, active low |
| per_wr_n | output | 1 | Peripheral write strobe, active low |
| ds_gate | output | 1 | 1 while controller strobes are passed to the bus |
| bus_uds_n | output | 1 | Gated upper data strobe to the bus |
| bus_lds_n | output | 1 | Gated lower data strobe to the bus |
| ready | output | 1 | Lockout flag, low during recovery |

## Verification
The assertions check on every cycle that:
- the two peripheral strobes are never low together;
- recovery keeps both strobes high and the gate closed;
- the gate opens in a read only after exactly the access count of read-strobe cycles;
- each recovery lasts exactly the recovery count;
- no strobe falls while ready is low.

Only the bench scenarios can show the rest. These are the synchronizer latency to each strobe edge, the pass-through of the controller's strobes with no clock delay, the end of the write keyed to the release of those strobes, that a mid-cycle direction change is ignored, and the single idle cycle before a held acknowledge restarts a transfer after recovery.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_PASS,
    ST_WR_WAIT,
    ST_WR_REL,
    ST_WR_HOLD,
    ST_RECOV
  } dss_state_t;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '1;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dss_timer.sv
module dss_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  output logic          zero
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (en && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dss_fsm.sv
module dss_fsm
  import dss_pkg::*;
#(
  parameter int ACCESS_CYC = 10,
  parameter int RECOV_CYC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_s,
  input  logic dir_s,
  input  logic uds_n_s,
  input  logic lds_n_s,
  output logic rd_n,
  output logic wr_n,
  output logic gate,
  output logic rdy
);
  localparam int MAXC = (ACCESS_CYC > RECOV_CYC) ? ACCESS_CYC : RECOV_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ACC_LOAD = CW'(ACCESS_CYC - 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(RECOV_CYC - 1);

  dss_state_t state_q, state_d;
  logic       t_load, t_en, t_zero;
  logic [CW-1:0] t_val;
  logic       strb_any, strb_none;

  assign strb_any  = !(uds_n_s && lds_n_s);
  assign strb_none = uds_n_s && lds_n_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (!ack_n_s) state_d = dir_s ? ST_WR_WAIT : ST_RD_ACC;
      ST_RD_ACC:  if (ack_n_s) state_d = ST_RECOV;
                  else if (t_zero) state_d = ST_RD_PASS;
      ST_RD_PASS: if (ack_n_s) state_d = ST_RECOV;
      ST_WR_WAIT: if (ack_n_s) state_d = ST_RECOV;
                  else if (strb_any) state_d = ST_WR_REL;
      ST_WR_REL:  if (ack_n_s) state_d = ST_RECOV;
                  else if (strb_none) state_d = ST_WR_HOLD;
      ST_WR_HOLD: if (ack_n_s) state_d = ST_RECOV;
      ST_RECOV:   if (t_zero) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign t_load = (state_d != state_q) &&
                  (state_d == ST_RD_ACC || state_d == ST_RECOV);
  assign t_val  = (state_d == ST_RD_ACC) ? ACC_LOAD : REC_LOAD;
  assign t_en   = (state_q == ST_RD_ACC) || (state_q == ST_RECOV);

  dss_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .en       (t_en),
    .zero     (t_zero)
  );

  assign rd_n = !(state_q == ST_RD_ACC || state_q == ST_RD_PASS);
  assign wr_n = !(state_q == ST_WR_WAIT || state_q == ST_WR_REL);
  assign gate = (state_q == ST_RD_PASS) || (state_q == ST_WR_WAIT) ||
                (state_q == ST_WR_REL)  || (state_q == ST_WR_HOLD);
  assign rdy  = (state_q != ST_RECOV);
endmodule

// File: rtl/dma_strobe_seq.sv
module dma_strobe_seq #(
  parameter int ACCESS_CYC  = 10,
  parameter int RECOV_CYC   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack0_n,
  input  logic ack1_n,
  input  logic dir_to_per,
  input  logic uds_n,
  input  logic lds_n,
  output logic per_rd_n,
  output logic per_wr_n,
  output logic ds_gate,
  output logic bus_uds_n,
  output logic bus_lds_n,
  output logic ready
);
  logic [4:0] raw, syn;

  assign raw = {ack0_n, ack1_n, dir_to_per, uds_n, lds_n};

  dss_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (syn)
  );

  dss_fsm #(.ACCESS_CYC(ACCESS_CYC), .RECOV_CYC(RECOV_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack_n_s (syn[4] & syn[3]),
    .dir_s   (syn[2]),
    .uds_n_s (syn[1]),
    .lds_n_s (syn[0]),
    .rd_n    (per_rd_n),
    .wr_n    (per_wr_n),
    .gate    (ds_gate),
    .rdy     (ready)
  );

  assign bus_uds_n = uds_n | ~ds_gate;
  assign bus_lds_n = lds_n | ~ds_gate;
endmodule

// File: rtl/dma_strobe_seq_chk.sv
module dma_strobe_seq_chk #(
  parameter int ACCESS_CYC = 10,
  parameter int RECOV_CYC  = 10
) (
  input logic clk,
  input logic rst_n,
  input logic per_rd_n,
  input logic per_wr_n,
  input logic ds_gate,
  input logic ready
);
  logic [15:0] rd_run, rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run  <= '0;
      rec_run <= '0;
    end else begin
      rd_run  <= per_rd_n ? 16'd0 : ((rd_run == 16'hffff) ? rd_run : rd_run + 16'd1);
      rec_run <= ready ? 16'd0 : ((rec_run == 16'hffff) ? rec_run : rec_run + 16'd1);
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!per_rd_n && !per_wr_n));

  p_recov_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (per_rd_n && per_wr_n && !ds_gate));

  p_access_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_gate) && !per_rd_n) |-> (rd_run == 16'(ACCESS_CYC)));

  p_recov_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (rec_run == 16'(RECOV_CYC)));

  p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(per_rd_n) || $fell(per_wr_n)) |-> $past(ready));
endmodule

bind dma_strobe_seq dma_strobe_seq_chk #(
  .ACCESS_CYC (ACCESS_CYC),
  .RECOV_CYC  (RECOV_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .per_rd_n (per_rd_n),
  .per_wr_n (per_wr_n),
  .ds_gate  (ds_gate),
  .ready    (ready)
);

// File: tb/dma_strobe_seq_tb.sv
`timescale 1ns/1ps
module dma_strobe_seq_tb;
  localparam int CLK_PERIOD = 25;
  localparam int ACC = 10;
  localparam int REC = 10;
  localparam int LAT = 3;

  logic clk, rst_n, ack0_n, ack1_n, dir_to_per, uds_n, lds_n;
  logic per_rd_n, per_wr_n, ds_gate, bus_uds_n, bus_lds_n, ready;
  int total, bad;

  dma_strobe_seq #(.ACCESS_CYC(ACC), .RECOV_CYC(REC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ack0_n(ack0_n), .ack1_n(ack1_n),
    .dir_to_per(dir_to_per), .uds_n(uds_n), .lds_n(lds_n),
    .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .ds_gate(ds_gate),
    .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .ready(ready));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_gate_rd(int n);
    return (n >= LAT + ACC);
  endfunction

  function automatic logic exp_rd_n(int n);
    return (n < LAT);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_cycle(bit a0, bit a1, int extra, bit flip);
    bit l;
    dir_to_per = 1'b0; ack0_n = !a0; ack1_n = !a1;
    for (int n = 1; n <= LAT + ACC; n++) begin
      step(1);
      chk("R1 rd strobe", per_rd_n, exp_rd_n(n));
      chk("R2 gate", ds_gate, exp_gate_rd(n));
      chk("R8 wr idle", per_wr_n, 1'b1);
      if (n == LAT && flip) dir_to_per = 1'b1;
    end
    l = 1'($urandom_range(0, 1));
    uds_n = 1'b0; lds_n = l;
    #1;
    chk("R2 bus uds pass", bus_uds_n, 1'b0);
    chk("R2 bus lds pass", bus_lds_n, l);
    step(extra);
    chk("R8 wr still idle", per_wr_n, 1'b1);
    uds_n = 1'b1; lds_n = 1'b1; ack0_n = 1'b1; ack1_n = 1'b1;
    step(LAT - 1);
    chk("R3 rd held", per_rd_n, 1'b0);
    step(1);
    chk("R3 rd released", per_rd_n, 1'b1);
    chk("R6 ready low", ready, 1'b0);
    dir_to_per = 1'b0;
  endtask

  task automatic finish_recov();
    step(REC - 1);
    chk("R6 ready still low", ready, 1'b0);
    step(1);
    chk("R6 ready back", ready, 1'b1);
  endtask

  task automatic wr_cycle(bit a0, bit a1, int pre, int hold, bit flip);
    dir_to_per = 1'b1; ack0_n = !a0; ack1_n = !a1; uds_n = 1'b1; lds_n = 1'b1;
    step(LAT - 1);
    chk("R1 wr not yet", per_wr_n, 1'b1);
    step(1);
    chk("R4 wr low", per_wr_n, 1'b0);
    chk("R4 gate open", ds_gate, 1'b1);
    chk("R10 rd idle", per_rd_n, 1'b1);
    if (flip) dir_to_per = 1'b0;
    lds_n = 1'b0;
    #1;
    chk("R4 lds passthrough", bus_lds_n, 1'b0);
    chk("R4 uds idle", bus_uds_n, 1'b1);
    step(pre);
    chk("R5 wr held", per_wr_n, 1'b0);
    chk("R8 no read", per_rd_n, 1'b1);
    lds_n = 1'b1;
    step(LAT - 1);
    chk("R5 wr not yet high", per_wr_n, 1'b0);
    step(1);
    chk("R5 wr latched high", per_wr_n, 1'b1);
    step(hold);
    ack0_n = 1'b1; ack1_n = 1'b1;
    step(LAT);
    chk("R6 ready low wr", ready, 1'b0);
    dir_to_per = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sd;
    total = 0; bad = 0;
    sd = $urandom(32'h5eed);
    rst_n = 1'b0; ack0_n = 1'b0; ack1_n = 1'b1; dir_to_per = 1'b0;
    uds_n = 1'b0; lds_n = 1'b0;
    step(4);
    chk("R9 rd reset", per_rd_n, 1'b1);
    chk("R9 wr reset", per_wr_n, 1'b1);
    chk("R9 gate reset", ds_gate, 1'b0);
    chk("R9 bus uds reset", bus_uds_n, 1'b1);
    chk("R9 ready reset", ready, 1'b1);
    ack0_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
    step(1);
    rst_n = 1'b1;
    step(3);

    rd_cycle(1, 0, 2, 0);  finish_recov();
    rd_cycle(0, 1, 0, 1);  finish_recov();
    rd_cycle(1, 1, 4, 0);  finish_recov();
    wr_cycle(1, 0, 3, 1, 0); finish_recov();
    wr_cycle(1, 1, 5, 0, 1); finish_recov();

    // R7: acknowledge held during recovery waits for ready
    rd_cycle(1, 0, 1, 0);
    ack0_n = 1'b0;
    step(REC - 1);
    chk("R7 locked rd", per_rd_n, 1'b1);
    chk("R7 ready low", ready, 1'b0);
    step(1);
    chk("R7 ready high", ready, 1'b1);
    chk("R7 idle gap", per_rd_n, 1'b1);
    step(1);
    chk("R7 restart", per_rd_n, 1'b0);
    ack0_n = 1'b1;
    step(LAT + REC + 1);
    chk("R7 settled", ready, 1'b1);

    for (int i = 0; i < 40; i++) begin
      int sel;
      sel = $urandom_range(1, 3);
      if ($urandom_range(0, 1) == 1)
        wr_cycle(sel[0], sel[1], $urandom_range(3, 6), $urandom_range(0, 4),
                 1'($urandom_range(0, 1)));
      else
        rd_cycle(sel[0], sel[1], $urandom_range(0, 6), 1'($urandom_range(0, 1)));
      finish_recov();
      step($urandom_range(0, 3));
    end

    // R9: reset in mid transfer forces idle outputs at once
    rd_cycle(1, 0, 0, 0);
    finish_recov();
    ack1_n = 1'b0;
    step(LAT + ACC + 1);
    uds_n = 1'b0;
    chk("R2 gate before reset", ds_gate, 1'b1);
    rst_n = 1'b0;
    #1;
    chk("R9 async rd", per_rd_n, 1'b1);
    chk("R9 async gate", ds_gate, 1'b0);
    chk("R9 async bus", bus_uds_n, 1'b1);
    chk("R9 async ready", ready, 1'b1);
    ack1_n = 1'b1; uds_n = 1'b1;
    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule